// File: doc/BRIEF.md
# Context Status Ring Writer

This block takes context-status events from an execution engine's scheduler and writes each one into a small circular buffer of six entries. Every event becomes a 64-bit record: the low 32-bit word carries the event flags and the high 32-bit word carries the context identifier. Both words of a record are written in the same cycle. The block then advances a write pointer that software can read. A read pointer sits beside it in the same register view.

After an empty reset the write pointer holds the marker value 7. The first event therefore lands in entry 0. From then on the pointer counts modulo six, not at a power of two. Each accepted event also produces a one-cycle mirror request. It carries the record and the updated pointer, so that a copy can be placed in a status page in memory. The request is only raised when the caller marks that page as usable. A context-switch interrupt pulse follows each record unless the event asks for the interrupt to be held back.

Events arrive through a valid/ready handshake, and the block takes one event per cycle with no gaps. A combinational read port lets the register view show any stored entry.

Top module: `ctxstat_ring_writer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the write pointer reads 7, the read pointer reads 0, every stored entry reads as zero, and the interrupt and mirror-valid outputs are low.
- R2: The first event accepted after reset is stored in entry 0, and the write pointer becomes 0.
- R3: Each accepted event moves the write pointer from 7 to 0, and from any other value v to (v+1) mod 6, so 5 is followed by 0. The pointer only ever holds 0 to 5 or 7.
- R4: An accepted event is stored at the entry given by the new write pointer. Its low word holds the flags: bit 0 idle-to-active, bit 1 preempted, bit 2 element-switch, bit 3 active-to-idle, bit 4 context-complete, bit 5 lite-restore, bits 31:6 zero. Its high word holds the 32-bit context ID. All of this is readable through the read port from the cycle after acceptance.
- R5: An accepted event with the defer input low raises the interrupt for exactly the one cycle that follows acceptance.
- R6: An accepted event with the defer input high raises no interrupt, and this has no effect on the interrupt of the next event.
- R7: In the cycle after an accepted event, mirror-valid is high exactly when the page-valid input was high with that event. The mirror outputs then carry the record's low word, its high word, and the new write pointer.
- R8: The ready output is high in every cycle after the first post-reset clock edge, so events offered on consecutive cycles are each accepted and stored in consecutive entries.
- R9: A cycle with no accepted event leaves the write pointer and the stored entries unchanged. The interrupt and mirror-valid outputs are low in the following cycle.
- R10: The read pointer output stays 0, because consumer-side reads are not part of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block can accept an event |
| ev_flags | input | 6 | Event flags, bit order as in R4 |
| ev_ctx_id | input | 32 | Context identifier of the event |
| ev_defer_irq | input | 1 | Suppress the interrupt for this event |
| page_ok | input | 1 | Status page address is valid for mirroring |
| wr_ptr | output | 3 | Register-visible write pointer |
| rd_ptr | output | 3 | Register-visible read pointer |
| rd_idx | input | 3 | Entry selected on the read port |
| rd_lo | output | 32 | Low word of the selected entry (0 if index is over 5) |
| rd_hi | output | 32 | High word of the selected entry (0 if index is over 5) |
| irq | output | 1 | One-cycle context-switch interrupt pulse |
| mir_valid | output | 1 | Mirror write request |
| mir_lo | output | 32 | Mirrored low word |
| mir_hi | output | 32 | Mirrored high word |
| mir_ptr | output | 3 | Mirrored new write pointer |

## Verification
The assertions check, on every clock cycle, that the pointer steps correctly and stays in its legal set, and that an idle cycle leaves it unchanged. They also check that the interrupt and the mirror request follow the defer and page-valid inputs of the event before them. What ends up stored in each entry, the exact flag and ID bit placement, and how long those values survive repeated wraps of the ring, can only be shown by the bench. It reads every entry back after long random sequences and directed wrap, defer and idle patterns.

// File: rtl/ctxstat_pkg.sv
package ctxstat_pkg;

    parameter int unsigned RING_DEPTH = 6;
    parameter int unsigned PTR_W      = 3;
    parameter int unsigned WORD_W     = 32;
    parameter int unsigned FLAG_W     = 6;

    localparam logic [PTR_W-1:0] EMPTY_MARK = {PTR_W{1'b1}};

    // Flag bits, LSB first: idle_to_act is bit 0
    typedef struct packed {
        logic lite_restore;
        logic ctx_complete;
        logic act_to_idle;
        logic elem_switch;
        logic preempted;
        logic idle_to_act;
    } ev_flags_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } rec_t;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] cur);
        logic [PTR_W:0] inc;
        if (cur == EMPTY_MARK) begin
            return '0;
        end
        inc = {1'b0, cur} + 1'b1;
        if (inc >= (PTR_W+1)'(RING_DEPTH)) begin
            inc = inc - (PTR_W+1)'(RING_DEPTH);
        end
        return inc[PTR_W-1:0];
    endfunction

    function automatic rec_t build_rec(input ev_flags_t fl, input logic [WORD_W-1:0] id);
        rec_t r;
        r.lo = {{(WORD_W-FLAG_W){1'b0}}, fl};
        r.hi = id;
        return r;
    endfunction

endpackage

// File: rtl/ctxstat_wptr.sv
module ctxstat_wptr
    import ctxstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_next
);

    always_comb begin
        ptr_next = step_ptr(ptr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= EMPTY_MARK;
        end else if (adv) begin
            ptr_q <= ptr_next;
        end
    end

endmodule

// File: rtl/ctxstat_store.sv
module ctxstat_store
    import ctxstat_pkg::*;
#(
    parameter int unsigned DEPTH = RING_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  rec_t              wrec,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rlo,
    output logic [WORD_W-1:0] rhi
);

    logic [WORD_W-1:0] lo_q [DEPTH];
    logic [WORD_W-1:0] hi_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit;
        assign hit = we && (waddr == PTR_W'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[e] <= '0;
                hi_q[e] <= '0;
            end else if (hit) begin
                lo_q[e] <= wrec.lo;
                hi_q[e] <= wrec.hi;
            end
        end
    end

    always_comb begin
        rlo = '0;
        rhi = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (raddr == PTR_W'(e)) begin
                rlo = lo_q[e];
                rhi = hi_q[e];
            end
        end
    end

endmodule

// File: rtl/ctxstat_notify.sv
module ctxstat_notify
    import ctxstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              defer,
    input  logic              page_ok,
    input  rec_t              rec,
    input  logic [PTR_W-1:0]  new_ptr,
    output logic              irq,
    output logic              mir_valid,
    output logic [WORD_W-1:0] mir_lo,
    output logic [WORD_W-1:0] mir_hi,
    output logic [PTR_W-1:0]  mir_ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            mir_valid <= 1'b0;
            mir_lo    <= '0;
            mir_hi    <= '0;
            mir_ptr   <= '0;
        end else begin
            irq       <= fire && !defer;
            mir_valid <= fire && page_ok;
            if (fire && page_ok) begin
                mir_lo  <= rec.lo;
                mir_hi  <= rec.hi;
                mir_ptr <= new_ptr;
            end
        end
    end

endmodule

// File: rtl/ctxstat_ring_writer.sv
module ctxstat_ring_writer
    import ctxstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [FLAG_W-1:0] ev_flags,
    input  logic [WORD_W-1:0] ev_ctx_id,
    input  logic              ev_defer_irq,
    input  logic              page_ok,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi,
    output logic              irq,
    output logic              mir_valid,
    output logic [WORD_W-1:0] mir_lo,
    output logic [WORD_W-1:0] mir_hi,
    output logic [PTR_W-1:0]  mir_ptr
);

    logic             accept;
    logic [PTR_W-1:0] ptr_next;
    rec_t             rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_ready <= 1'b0;
        end else begin
            ev_ready <= 1'b1;
        end
    end

    assign accept = ev_valid && ev_ready;
    assign rec    = build_rec(ev_flags_t'(ev_flags), ev_ctx_id);
    assign rd_ptr = '0;

    ctxstat_wptr u_wptr (
        .clk      (clk),
        .rst      (rst),
        .adv      (accept),
        .ptr_q    (wr_ptr),
        .ptr_next (ptr_next)
    );

    ctxstat_store #(.DEPTH(RING_DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .waddr (ptr_next),
        .wrec  (rec),
        .raddr (rd_idx),
        .rlo   (rd_lo),
        .rhi   (rd_hi)
    );

    ctxstat_notify u_notify (
        .clk       (clk),
        .rst       (rst),
        .fire      (accept),
        .defer     (ev_defer_irq),
        .page_ok   (page_ok),
        .rec       (rec),
        .new_ptr   (ptr_next),
        .irq       (irq),
        .mir_valid (mir_valid),
        .mir_lo    (mir_lo),
        .mir_hi    (mir_hi),
        .mir_ptr   (mir_ptr)
    );

endmodule

// File: rtl/ctxstat_ring_writer_chk.sv
module ctxstat_ring_writer_chk
    import ctxstat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [FLAG_W-1:0] ev_flags,
    input logic [WORD_W-1:0] ev_ctx_id,
    input logic              ev_defer_irq,
    input logic              page_ok,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              irq,
    input logic              mir_valid,
    input logic [WORD_W-1:0] mir_lo,
    input logic [WORD_W-1:0] mir_hi,
    input logic [PTR_W-1:0]  mir_ptr
);

    logic acc;
    assign acc = ev_valid && ev_ready;

    // R3: legal pointer values only
    a_r3_ptr_legal: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr < PTR_W'(RING_DEPTH)) || (wr_ptr == EMPTY_MARK));

    // R3: empty marker advances to entry 0
    a_r3_from_empty: assert property (@(posedge clk) disable iff (rst)
        (acc && wr_ptr == EMPTY_MARK) |=> (wr_ptr == '0));

    // R3: last entry wraps to 0
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (acc && wr_ptr == PTR_W'(RING_DEPTH-1)) |=> (wr_ptr == '0));

    // R5: interrupt pulse after an undeferred event
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        (acc && !ev_defer_irq) |=> irq);

    // R6: deferred event raises no interrupt
    a_r6_defer_quiet: assert property (@(posedge clk) disable iff (rst)
        (acc && ev_defer_irq) |=> !irq);

    // R7: mirror request carries the record and the new pointer
    a_r7_mirror: assert property (@(posedge clk) disable iff (rst)
        (acc && page_ok) |=> (mir_valid && mir_ptr == wr_ptr
            && mir_lo == $past({{(WORD_W-FLAG_W){1'b0}}, ev_flags})
            && mir_hi == $past(ev_ctx_id)));

    // R7: no mirror request without a valid page
    a_r7_no_page: assert property (@(posedge clk) disable iff (rst)
        (acc && !page_ok) |=> !mir_valid);

    // R8: ready after the first post-reset edge
    a_r8_ready: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ev_ready);

    // R9: idle cycle changes nothing
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(wr_ptr) && !irq && !mir_valid));

endmodule

bind ctxstat_ring_writer ctxstat_ring_writer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (ev_valid),
    .ev_ready     (ev_ready),
    .ev_flags     (ev_flags),
    .ev_ctx_id    (ev_ctx_id),
    .ev_defer_irq (ev_defer_irq),
    .page_ok      (page_ok),
    .wr_ptr       (wr_ptr),
    .irq          (irq),
    .mir_valid    (mir_valid),
    .mir_lo       (mir_lo),
    .mir_hi       (mir_hi),
    .mir_ptr      (mir_ptr)
);

// File: tb/tb_ctxstat_ring_writer.sv
`timescale 1ns/1ps
module tb_ctxstat_ring_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [5:0]  ev_flags = '0;
    logic [31:0] ev_ctx_id = '0;
    logic        ev_defer_irq = 1'b0;
    logic        page_ok = 1'b0;
    logic [2:0]  wr_ptr, rd_ptr;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_lo, rd_hi;
    logic        irq, mir_valid;
    logic [31:0] mir_lo, mir_hi;
    logic [2:0]  mir_ptr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] m_lo [6];
    logic [31:0] m_hi [6];
    logic [2:0]  m_ptr;

    always #2 clk = ~clk;

    ctxstat_ring_writer dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_flags(ev_flags), .ev_ctx_id(ev_ctx_id), .ev_defer_irq(ev_defer_irq),
        .page_ok(page_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_idx(rd_idx),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .irq(irq), .mir_valid(mir_valid),
        .mir_lo(mir_lo), .mir_hi(mir_hi), .mir_ptr(mir_ptr)
    );

    function automatic logic [2:0] exp_step(input logic [2:0] p);
        if (p == 3'd7) return 3'd0;
        return (p == 3'd5) ? 3'd0 : p + 3'd1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one cycle: drive at negedge, check just after the posedge
    task automatic cycle(input bit v, input logic [5:0] fl, input logic [31:0] id,
                         input bit dfr, input bit pg);
        logic [2:0] np;
        @(negedge clk);
        ev_valid = v; ev_flags = fl; ev_ctx_id = id; ev_defer_irq = dfr; page_ok = pg;
        @(posedge clk);
        #1;
        if (v) begin
            np = exp_step(m_ptr);
            m_ptr = np;
            m_lo[np] = {26'd0, fl};
            m_hi[np] = id;
            chk("R3 wr_ptr", 64'(wr_ptr), 64'(np));
            chk(dfr ? "R6 irq deferred" : "R5 irq pulse", 64'(irq), 64'(!dfr));
            chk("R7 mir_valid", 64'(mir_valid), 64'(pg));
            if (pg) chk("R7 mirror record", {mir_hi, mir_lo}, {id, 26'd0, fl});
            if (pg) chk("R7 mirror ptr", 64'(mir_ptr), 64'(np));
            rd_idx = np;
            #1;
            chk("R4 stored record", {rd_hi, rd_lo}, {id, 26'd0, fl});
        end else begin
            chk("R9 idle ptr", 64'(wr_ptr), 64'(m_ptr));
            chk("R9 idle irq/mirror", {62'd0, irq, mir_valid}, 64'd0);
        end
        ev_valid = 1'b0;
    endtask

    task automatic scan_all(input string req);
        for (int e = 0; e < 6; e++) begin
            rd_idx = 3'(e);
            #0.2;
            chk(req, {rd_hi, rd_lo}, {m_hi[e], m_lo[e]});
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        bit prev_defer;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int e = 0; e < 6; e++) begin m_lo[e] = '0; m_hi[e] = '0; end
        m_ptr = 3'd7;

        repeat (3) @(posedge clk);
        #1;
        // R1: state during reset
        chk("R1 wr_ptr in reset", 64'(wr_ptr), 64'd7);
        chk("R1 rd_ptr in reset", 64'(rd_ptr), 64'd0);
        chk("R1 irq/mirror in reset", {62'd0, irq, mir_valid}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 wr_ptr after reset", 64'(wr_ptr), 64'd7);
        chk("R8 ready", 64'(ev_ready), 64'd1);
        scan_all("R1 entries cleared");

        // R2: first write goes to entry 0
        cycle(1, 6'b000001, 32'hA0A0_0001, 0, 1);
        chk("R2 first entry", 64'(wr_ptr), 64'd0);

        // R3/R8: back-to-back through a wrap
        for (int k = 0; k < 7; k++)
            cycle(1, 6'(1 << (k % 6)), 32'hB000_0000 + 32'(k), 0, 0);
        chk("R3 wrap position", 64'(wr_ptr), 64'(m_ptr));
        scan_all("R8 back-to-back entries");

        // R6: defer then undeferred
        cycle(1, 6'b010000, 32'hC0DE_0001, 1, 1);
        cycle(1, 6'b001000, 32'hC0DE_0002, 0, 1);
        // R9: idle cycles
        cycle(0, 6'b111111, 32'hFFFF_FFFF, 0, 1);
        cycle(0, 6'b100000, 32'h1234_5678, 1, 0);
        scan_all("R9 entries unchanged");

        // random mix
        prev_defer = 0;
        for (int k = 0; k < 400; k++) begin
            bit v;
            v = ($urandom % 4) != 0;
            cycle(v, 6'($urandom), $urandom, bit'($urandom % 2), bit'($urandom % 2));
            if (k % 50 == 0) scan_all("R4 random entries");
        end
        scan_all("R4 final entries");
        chk("R10 rd_ptr", 64'(rd_ptr), 64'd0);
        chk("R8 ready end", 64'(ev_ready), 64'd1);
        finish_run();
    end

endmodule